// File: doc/BRIEF.md
# Register and Predicate Remap Table

This block holds two small associative tables that tell an instruction-issue stage how to treat a register operand. The register table marks a register as vectorised. Each entry maps a key to a replacement start register and an element-width code. The key is a register-file select bit plus a 5-bit register number. The predicate table uses the same kind of key. Each of its entries names the register holding predicate bits, an invert control and a zero-non-predicated control.

Software fills the tables with CSR-style writes. A write carries a table select, an entry index and one packed field word, and it lands on the next clock edge. Two combinational lookup ports search the tables by key and return the fields of the matching entry together with a hit flag. On a miss they return neutral values, so the operand is treated as plain scalar or unpredicated. The predicate lookup also takes the raw predicate word that was read from the named register. It returns the effective element mask, with inversion applied.

Top module: `vrmap_table`

## Requirements
- R1: A write with `wr_sel`=0 stores a register-table entry at `wr_idx`. The packed word is: bit 0 valid, bit 1 register-file select (1 = floating point), bits 6:2 key register, bits 11:7 start register, bits 14:12 element-width code. A lookup made in the same cycle as the write still returns the old contents. From the next cycle the lookup returns the new contents.
- R2: A write with `wr_sel`=1 stores a predicate-table entry at `wr_idx`. The packed word is: bit 0 valid, bit 1 register-file select, bits 6:2 key register, bits 11:7 predicate register, bit 12 invert, bit 13 zero-non-predicated. Bit 14 is ignored.
- R3: An entry matches only when both its register-file select bit and its 5-bit register number equal the query. Integer register 3 and floating-point register 3 are distinct keys.
- R4: A register lookup that matches no valid entry drives `rq_hit`=0 and `rq_ew`=0. It also drives `rq_start` equal to the queried register number.
- R5: A predicate lookup that matches no valid entry drives `pq_hit`=0, `pq_preg`=0, `pq_inv`=0 and `pq_zero`=0. It also drives `pq_mask` to all ones.
- R6: When several valid entries hold the same key, the entry with the lowest index supplies the result.
- R7: Writing an entry with its valid bit clear removes it from matching.
- R8: On a predicate hit, `pq_mask` equals `pq_raw` when the entry's invert bit is 0. It equals the bitwise complement of `pq_raw` when the invert bit is 1.
- R9: Element-width codes are 0 = default, 1 = 8, 2 = 16, 3 = 32 and 4 = 64 bits. Codes 5 to 7 are reserved. The code is returned unchanged. `rq_ew_rsvd` is 1 exactly when the returned code is 5, 6 or 7.
- R10: A synchronous active-high reset clears every entry of both tables. After the reset edge, every lookup misses.
- R11: A write to one table leaves the other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Table select: 0 register table, 1 predicate table |
| wr_idx | input | $clog2(NENT) | Entry index to write |
| wr_data | input | 15 | Packed entry fields |
| rq_fp | input | 1 | Register lookup: register-file select of the query |
| rq_reg | input | 5 | Register lookup: queried register number |
| rq_hit | output | 1 | Register lookup matched a valid entry |
| rq_start | output | 5 | Start register to use (queried register on a miss) |
| rq_ew | output | 3 | Element-width code (0 on a miss) |
| rq_ew_rsvd | output | 1 | Returned width code is a reserved one |
| pq_fp | input | 1 | Predicate lookup: register-file select of the query |
| pq_reg | input | 5 | Predicate lookup: queried register number |
| pq_raw | input | PW | Raw predicate word read from the predicate register |
| pq_hit | output | 1 | Predicate lookup matched a valid entry |
| pq_preg | output | 5 | Register holding the predicate bits |
| pq_inv | output | 1 | Invert control of the matched entry |
| pq_zero | output | 1 | Zero-non-predicated control of the matched entry |
| pq_mask | output | PW | Effective element mask |

## Verification
Both lookup ports are combinational from the stored entries and the query inputs. A lookup result therefore changes a settling delay after its query inputs change, with no clock involved. A write or a reset changes the stored entries at one clock edge, so the lookup result changes just after that edge. The bench drives every input on the falling edge and samples one time unit later. A write is checked in the cycle after its edge, and one check deliberately samples in the cycle of the write itself to confirm that the old contents are still returned.

// File: rtl/vrmap_pkg.sv
package vrmap_pkg;

  localparam int RNUM_W = 5;
  localparam int KEY_W  = RNUM_W + 1;
  localparam int EW_W   = 3;

  typedef enum logic [EW_W-1:0] {
    EW_DEF = 3'd0,
    EW_8   = 3'd1,
    EW_16  = 3'd2,
    EW_32  = 3'd3,
    EW_64  = 3'd4
  } ew_code_e;

  // register-table entry, LSB first: vld, fp, key, start, ew
  typedef struct packed {
    logic [EW_W-1:0]   ew;
    logic [RNUM_W-1:0] start;
    logic [RNUM_W-1:0] key;
    logic              fp;
    logic              vld;
  } reg_ent_t;

  // predicate-table entry, LSB first: vld, fp, key, preg, inv, zero
  typedef struct packed {
    logic              zero;
    logic              inv;
    logic [RNUM_W-1:0] preg;
    logic [RNUM_W-1:0] key;
    logic              fp;
    logic              vld;
  } prd_ent_t;

  localparam int REG_ENT_W = $bits(reg_ent_t);
  localparam int PRD_ENT_W = $bits(prd_ent_t);
  localparam int WD_W      = (REG_ENT_W > PRD_ENT_W) ? REG_ENT_W : PRD_ENT_W;

endpackage

// File: rtl/vrmap_store.sv
module vrmap_store #(
  parameter int N  = 8,
  parameter int W  = 15,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IW-1:0]       widx,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);

  logic [N-1:0][W-1:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign q = mem;

endmodule

// File: rtl/vrmap_match.sv
module vrmap_match #(
  parameter int N  = 8,
  parameter int KW = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][KW-1:0] keys,
  input  logic [KW-1:0]        qkey,
  output logic                 hit,
  output logic [IW-1:0]        idx
);

  // scan downward so the lowest matching index is the last one kept
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i] && (keys[i] == qkey)) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/vrmap_table.sv
module vrmap_table
  import vrmap_pkg::*;
#(
  parameter int NENT = 8,
  parameter int PW   = 32,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IW-1:0]     wr_idx,
  input  logic [WD_W-1:0]   wr_data,
  input  logic              rq_fp,
  input  logic [RNUM_W-1:0] rq_reg,
  output logic              rq_hit,
  output logic [RNUM_W-1:0] rq_start,
  output logic [EW_W-1:0]   rq_ew,
  output logic              rq_ew_rsvd,
  input  logic              pq_fp,
  input  logic [RNUM_W-1:0] pq_reg,
  input  logic [PW-1:0]     pq_raw,
  output logic              pq_hit,
  output logic [RNUM_W-1:0] pq_preg,
  output logic              pq_inv,
  output logic              pq_zero,
  output logic [PW-1:0]     pq_mask
);

  logic [NENT-1:0][REG_ENT_W-1:0] r_q;
  logic [NENT-1:0][PRD_ENT_W-1:0] p_q;
  reg_ent_t                       r_ent [NENT];
  prd_ent_t                       p_ent [NENT];
  logic [NENT-1:0]                r_vld, p_vld;
  logic [NENT-1:0][KEY_W-1:0]     r_key, p_key;
  logic                           r_hit, p_hit;
  logic [IW-1:0]                  r_idx, p_idx;
  reg_ent_t                       r_sel;
  prd_ent_t                       p_sel;

  // storage: one array per table, selected by wr_sel
  vrmap_store #(.N(NENT), .W(REG_ENT_W)) u_rstore (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en && !wr_sel),
    .widx  (wr_idx),
    .wdata (wr_data[REG_ENT_W-1:0]),
    .q     (r_q)
  );

  vrmap_store #(.N(NENT), .W(PRD_ENT_W)) u_pstore (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en && wr_sel),
    .widx  (wr_idx),
    .wdata (wr_data[PRD_ENT_W-1:0]),
    .q     (p_q)
  );

  // per-entry key and valid extraction
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign r_ent[g] = reg_ent_t'(r_q[g]);
    assign p_ent[g] = prd_ent_t'(p_q[g]);
    assign r_vld[g] = r_ent[g].vld;
    assign p_vld[g] = p_ent[g].vld;
    assign r_key[g] = {r_ent[g].fp, r_ent[g].key};
    assign p_key[g] = {p_ent[g].fp, p_ent[g].key};
  end

  vrmap_match #(.N(NENT), .KW(KEY_W)) u_rmatch (
    .vld  (r_vld),
    .keys (r_key),
    .qkey ({rq_fp, rq_reg}),
    .hit  (r_hit),
    .idx  (r_idx)
  );

  vrmap_match #(.N(NENT), .KW(KEY_W)) u_pmatch (
    .vld  (p_vld),
    .keys (p_key),
    .qkey ({pq_fp, pq_reg}),
    .hit  (p_hit),
    .idx  (p_idx)
  );

  assign r_sel = r_ent[r_idx];
  assign p_sel = p_ent[p_idx];

  // register lookup: identity mapping on a miss
  always_comb begin
    rq_hit     = r_hit;
    rq_start   = r_hit ? r_sel.start : rq_reg;
    rq_ew      = r_hit ? r_sel.ew : EW_DEF;
    rq_ew_rsvd = (rq_ew > EW_64);
  end

  // predicate lookup: all elements enabled on a miss
  always_comb begin
    pq_hit  = p_hit;
    pq_preg = p_hit ? p_sel.preg : '0;
    pq_inv  = p_hit && p_sel.inv;
    pq_zero = p_hit && p_sel.zero;
    if (!p_hit) begin
      pq_mask = '1;
    end else if (p_sel.inv) begin
      pq_mask = ~pq_raw;
    end else begin
      pq_mask = pq_raw;
    end
  end

endmodule

// File: rtl/vrmap_chk.sv
module vrmap_chk
  import vrmap_pkg::*;
#(
  parameter int PW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [WD_W-1:0]   wr_data,
  input logic              rq_fp,
  input logic [RNUM_W-1:0] rq_reg,
  input logic              rq_hit,
  input logic [RNUM_W-1:0] rq_start,
  input logic [EW_W-1:0]   rq_ew,
  input logic              rq_ew_rsvd,
  input logic [PW-1:0]     pq_raw,
  input logic              pq_hit,
  input logic [RNUM_W-1:0] pq_preg,
  input logic              pq_inv,
  input logic              pq_zero,
  input logic [PW-1:0]     pq_mask
);

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!rq_hit && !pq_hit));

  // R4
  reg_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !rq_hit |-> (rq_start == rq_reg && rq_ew == 3'd0));

  // R5
  prd_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !pq_hit |-> (pq_mask == {PW{1'b1}} && !pq_inv && !pq_zero && pq_preg == '0));

  // R8
  mask_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (pq_hit && !pq_inv) |-> (pq_mask == pq_raw));

  // R8
  mask_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (pq_hit && pq_inv) |-> (pq_mask == ~pq_raw));

  // R9
  ew_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    rq_ew_rsvd == (rq_ew > 3'd4));

  // R1
  wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_data[0] && rq_fp == wr_data[1] && rq_reg == wr_data[6:2])
    ##1 (rq_fp == $past(rq_fp) && rq_reg == $past(rq_reg)) |-> rq_hit);

endmodule

bind vrmap_table vrmap_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rq_fp      (rq_fp),
  .rq_reg     (rq_reg),
  .rq_hit     (rq_hit),
  .rq_start   (rq_start),
  .rq_ew      (rq_ew),
  .rq_ew_rsvd (rq_ew_rsvd),
  .pq_raw     (pq_raw),
  .pq_hit     (pq_hit),
  .pq_preg    (pq_preg),
  .pq_inv     (pq_inv),
  .pq_zero    (pq_zero),
  .pq_mask    (pq_mask)
);

// File: tb/sim_vrmap_table.sv
module sim_vrmap_table;

  localparam int NENT = 8;
  localparam int PW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [14:0]   wr_data = '0;
  logic          rq_fp = 1'b0;
  logic [4:0]    rq_reg = '0;
  logic          rq_hit;
  logic [4:0]    rq_start;
  logic [2:0]    rq_ew;
  logic          rq_ew_rsvd;
  logic          pq_fp = 1'b0;
  logic [4:0]    pq_reg = '0;
  logic [PW-1:0] pq_raw = '0;
  logic          pq_hit;
  logic [4:0]    pq_preg;
  logic          pq_inv;
  logic          pq_zero;
  logic [PW-1:0] pq_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vrmap_table #(.NENT(NENT), .PW(PW)) u0 (.*);

  typedef struct packed {
    logic        we;
    logic [2:0]  idx;
    logic [14:0] d;
    logic        qfp;
    logic [4:0]  qreg;
    logic        ehit;
    logic [4:0]  estart;
    logic [2:0]  eew;
    logic        ersvd;
  } vec_t;

  // register-table word: {ew, start, key, fp, vld}
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'd2, {3'd2, 5'd10, 5'd3,  1'b0, 1'b1}, 1'b0, 5'd3,  1'b1, 5'd10, 3'd2, 1'b0}, // R1
    '{1'b0, 3'd0, 15'd0,                             1'b1, 5'd3,  1'b0, 5'd3,  3'd0, 1'b0}, // R3 R4
    '{1'b1, 3'd5, {3'd4, 5'd20, 5'd3,  1'b1, 1'b1}, 1'b1, 5'd3,  1'b1, 5'd20, 3'd4, 1'b0}, // R3
    '{1'b1, 3'd1, {3'd1, 5'd12, 5'd3,  1'b0, 1'b1}, 1'b0, 5'd3,  1'b1, 5'd12, 3'd1, 1'b0}, // R6
    '{1'b1, 3'd1, {3'd1, 5'd12, 5'd3,  1'b0, 1'b0}, 1'b0, 5'd3,  1'b1, 5'd10, 3'd2, 1'b0}, // R7
    '{1'b1, 3'd7, {3'd6, 5'd0,  5'd31, 1'b0, 1'b1}, 1'b0, 5'd31, 1'b1, 5'd0,  3'd6, 1'b1}, // R9
    '{1'b0, 3'd0, 15'd0,                             1'b0, 5'd17, 1'b0, 5'd17, 3'd0, 1'b0}, // R4
    '{1'b1, 3'd2, {3'd2, 5'd10, 5'd3,  1'b0, 1'b0}, 1'b0, 5'd3,  1'b0, 5'd3,  3'd0, 1'b0}  // R7
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] idx, input logic [14:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rq_fp = 1'b0; rq_reg = 5'd3; pq_fp = 1'b0; pq_reg = 5'd5; #1;
    chk("R10 rq_hit after reset", 32'(rq_hit), 32'd0);
    chk("R10 pq_hit after reset", 32'(pq_hit), 32'd0);
    chk("R5 miss mask", pq_mask, 32'hFFFF_FFFF);

    // vector walk over the register table
    foreach (VECS[i]) begin
      if (VECS[i].we) wr(1'b0, VECS[i].idx, VECS[i].d);
      else @(negedge clk);
      rq_fp = VECS[i].qfp; rq_reg = VECS[i].qreg; #1;
      chk($sformatf("R1/R3/R4/R6/R7/R9 vec%0d hit", i), 32'(rq_hit), 32'(VECS[i].ehit));
      chk($sformatf("R1/R4/R6/R7 vec%0d start", i), 32'(rq_start), 32'(VECS[i].estart));
      chk($sformatf("R9 vec%0d ew", i), 32'(rq_ew), 32'(VECS[i].eew));
      chk($sformatf("R9 vec%0d rsvd", i), 32'(rq_ew_rsvd), 32'(VECS[i].ersvd));
    end

    // R1 same-cycle write is not yet visible
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 3'd4;
    wr_data = {3'd3, 5'd25, 5'd9, 1'b0, 1'b1};
    rq_fp = 1'b0; rq_reg = 5'd9; #1;
    chk("R1 old contents in write cycle", 32'(rq_hit), 32'd0);
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R1 new start next cycle", 32'(rq_start), 32'd25);

    // R2 predicate write: {zero, inv, preg, key, fp, vld}
    wr(1'b1, 3'd3, {1'b0, 1'b0, 1'b1, 5'd9, 5'd5, 1'b0, 1'b1});
    pq_fp = 1'b0; pq_reg = 5'd5; pq_raw = 32'hA5A5_0F0F; #1;
    chk("R2 pq_hit", 32'(pq_hit), 32'd1);
    chk("R2 pq_preg", 32'(pq_preg), 32'd9);
    chk("R2 pq_zero", 32'(pq_zero), 32'd0);
    chk("R8 inverted mask", pq_mask, 32'h5A5A_F0F0);

    // R2 bit 14 ignored, R6 lower index wins, R8 plain mask
    wr(1'b1, 3'd0, {1'b1, 1'b1, 1'b0, 5'd7, 5'd5, 1'b0, 1'b1});
    #1;
    chk("R6 pred lower index preg", 32'(pq_preg), 32'd7);
    chk("R2 zero flag", 32'(pq_zero), 32'd1);
    chk("R8 plain mask", pq_mask, 32'hA5A5_0F0F);

    // R3 predicate fp key distinct
    pq_fp = 1'b1; #1;
    chk("R3 pred fp miss", 32'(pq_hit), 32'd0);
    pq_fp = 1'b0;

    // R11 predicate writes leave the register table alone
    rq_fp = 1'b0; rq_reg = 5'd5; #1;
    chk("R11 reg table untouched", 32'(rq_hit), 32'd0);
    wr(1'b0, 3'd0, {3'd1, 5'd2, 5'd5, 1'b0, 1'b1});
    #1;
    chk("R11 pred table untouched", 32'(pq_preg), 32'd7);

    // R7 remove predicate entry 0, entry 3 shows through
    wr(1'b1, 3'd0, 15'd0);
    #1;
    chk("R7 pred removal", 32'(pq_preg), 32'd9);

    // R10 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rq_fp = 1'b0; rq_reg = 5'd9; #1;
    chk("R10 reg cleared", 32'(rq_hit), 32'd0);
    chk("R10 pred cleared", 32'(pq_hit), 32'd0);
    chk("R5 mask after reset", pq_mask, 32'hFFFF_FFFF);

    finish_run();
  end

endmodule